// File: doc/BRIEF.md
# Delayed-Write Banked Cartridge Controller

This block sits on a 13-bit processor address bus that has no data-write path into the cartridge. It maps two 2K windows of cartridge space onto a store of four 2K banks: three RAM banks (0, 1, 2) and one ROM bank (3). Address bit 12 marks a cartridge access. Address bit 11 picks the lower or the upper window, and bits 10..0 give the byte offset inside the bank mapped to that window. The store itself lives outside the block. The block drives the store's bank-plus-offset address every cycle, together with a write strobe and write data.

RAM is written without a write cycle on the bus. Touching a cartridge address whose bits 11..8 are all zero captures address bits 7..0 as a data byte and arms a pending write. If writes are enabled, the byte lands in the location the bus addresses on exactly the fifth distinct access after the capture. A cartridge access to address 0x1FF8 takes the captured byte as a new configuration word. That word sets the write-enable flag and the banks seen through the two windows.

A distinct access is a cycle whose address differs from the previous cycle's address. A cycle that holds the same address is treated as part of the same access, so it advances no counter and triggers no action.

Top module: `sc_bank_ctrl`

## Requirements
- R1: In every cycle, store_addr_o equals {bank, addr_i[10:0]}. The bank is the lower-window bank when addr_i[11]=0 and the upper-window bank when addr_i[11]=1. A configuration change takes effect from the cycle after the hotspot access.
- R2: After reset, writes are disabled, no write is pending, the lower window shows bank 0 and the upper window shows bank 3 (ROM). No store write happens until a configuration enables writes.
- R3: An access is counted only when addr_i differs from the previous cycle's addr_i (the first cycle after reset also counts). Repeated cycles on the same address neither advance the count nor repeat a write.
- R4: A distinct access with addr_i[12]=1 and addr_i[11:8]=0 captures addr_i[7:0] into the hold byte, restarts the count and arms a pending write. It does this only when writes are disabled or no write is pending.
- R5: With writes enabled and a write pending, the fifth distinct access after the capture that is a cartridge access asserts store_we_o for that one cycle. store_wdata_o then equals the hold byte and store_addr_o equals the addressed location. The pending write is then cleared.
- R6: Once more than five distinct accesses have passed since the capture, a pending write is dropped and no later access writes it.
- R7: A write aimed at the upper window while bank 3 is mapped there is discarded, although the pending write is still consumed. A write aimed at the lower window always goes to the lower-window bank.
- R8: A distinct access to 0x1FF8 clears any pending write and applies the hold byte as the configuration. Bit 1 is the write enable. Bits 4..2 form a map index i, which selects (lower, upper) banks as follows: 0:(0,3), 1:(1,3), 2:(2,3), 3:(0,1), 4:(1,2), 5:(2,0), 6:(0,2), 7:(1,0).
- R9: While writes are enabled and a write is pending, an access in the capture range does not recapture. It counts as an ordinary access and can itself be the write target.
- R10: An access with addr_i[12]=0 counts as a distinct access but never captures, writes or reconfigures. A pending write whose fifth access falls outside cartridge space is therefore lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus cycle per edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 13 | Bus address; bit 12 marks cartridge space |
| store_addr_o | output | 13 | Store address: bank in bits 12..11, offset in 10..0 |
| store_we_o | output | 1 | Store write strobe for this cycle |
| store_wdata_o | output | 8 | Byte to write, the captured hold byte |

## Verification
The mapping is swept over all eight map indices with writes both enabled and disabled. Each combination gets one read in each window and one delayed write aimed at either window, which separates correct table decoding, the ROM write protection and the write-enable gating. The write delay is swept from zero to eight filler accesses between capture and target, so an early write, a late write and a missed cancellation each show up as a wrong strobe. Further sequences hold one address for many cycles to show that repeats do not count. They also place a capture-range address inside an armed window, put the fifth access outside cartridge space, and check that a reset-state capture never writes.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;
  localparam int BANK_W      = 2;
  localparam int CFG_WEN_BIT = 1;
  localparam int CFG_MAP_LSB = 2;
  localparam int MAP_IDX_W   = 3;

  typedef struct packed {
    logic [BANK_W-1:0] lo;
    logic [BANK_W-1:0] hi;
  } slot_map_t;

  // Map index to (lower window bank, upper window bank)
  function automatic slot_map_t map_lookup(input logic [MAP_IDX_W-1:0] idx);
    slot_map_t m;
    case (idx)
      3'd0:    m = '{lo: 2'd0, hi: 2'd3};
      3'd1:    m = '{lo: 2'd1, hi: 2'd3};
      3'd2:    m = '{lo: 2'd2, hi: 2'd3};
      3'd3:    m = '{lo: 2'd0, hi: 2'd1};
      3'd4:    m = '{lo: 2'd1, hi: 2'd2};
      3'd5:    m = '{lo: 2'd2, hi: 2'd0};
      3'd6:    m = '{lo: 2'd0, hi: 2'd2};
      default: m = '{lo: 2'd1, hi: 2'd0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sc_access_tracker.sv
module sc_access_tracker #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              age_clr_i,
  output logic              distinct_o,
  output logic [CNT_W-1:0]  age_o,
  output logic [CNT_W-1:0]  age_next_o
);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  logic [ADDR_W-1:0] prev_q;
  logic              seen_q;
  logic [CNT_W-1:0]  age_q;

  assign distinct_o = !seen_q || (addr_i != prev_q);
  // saturating so a long idle stretch never wraps back into the window
  assign age_next_o = (age_q == AGE_MAX) ? AGE_MAX : age_q + 1'b1;
  assign age_o      = age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
      age_q  <= AGE_MAX;
    end else begin
      prev_q <= addr_i;
      seen_q <= 1'b1;
      if (distinct_o) age_q <= age_clr_i ? '0 : age_next_o;
    end
  end

  AST_REPEAT_HOLDS_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !distinct_o |=> $stable(age_q)); // R3
endmodule

// File: rtl/sc_slot_mapper.sv
module sc_slot_mapper
  import sc_bank_pkg::*;
#(
  parameter int               OFF_W    = 11,
  parameter int               DATA_W   = 8,
  parameter logic [BANK_W-1:0] ROM_BANK = 2'd3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_apply_i,
  input  logic [DATA_W-1:0]       cfg_byte_i,
  input  logic                    slot_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic [BANK_W+OFF_W-1:0] store_addr_o,
  output logic                    wen_o,
  output logic                    wr_blocked_o
);
  slot_map_t         map_q;
  logic              wen_q;
  logic [BANK_W-1:0] bank;
  slot_map_t         map_rst;

  assign map_rst = map_lookup('0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= map_rst;
      wen_q <= 1'b0;
    end else if (cfg_apply_i) begin
      map_q <= map_lookup(cfg_byte_i[CFG_MAP_LSB +: MAP_IDX_W]);
      wen_q <= cfg_byte_i[CFG_WEN_BIT];
    end
  end

  assign bank         = slot_i ? map_q.hi : map_q.lo;
  assign store_addr_o = {bank, off_i};
  assign wen_o        = wen_q;
  assign wr_blocked_o = slot_i && (map_q.hi == ROM_BANK);

  AST_CFG_TAKES_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_apply_i |=> (wen_o == $past(cfg_byte_i[CFG_WEN_BIT]))); // R8
endmodule

// File: rtl/sc_write_sequencer.sv
module sc_write_sequencer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int DELAY  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              distinct_i,
  input  logic              cart_i,
  input  logic              range_hit_i,
  input  logic              hotspot_hit_i,
  input  logic [DATA_W-1:0] latch_byte_i,
  input  logic [CNT_W-1:0]  age_i,
  input  logic [CNT_W-1:0]  age_next_i,
  input  logic              wen_i,
  input  logic              wr_blocked_i,
  output logic              latch_o,
  output logic              cfg_apply_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              store_we_o
);
  localparam logic [CNT_W-1:0] DLY = CNT_W'(DELAY);

  logic [DATA_W-1:0] hold_q;
  logic              pending_q;
  logic              cancel, pend_eff, wr_slot, pending_d;

  assign cancel   = pending_q && (age_next_i > DLY);
  assign pend_eff = pending_q && !cancel;

  assign latch_o     = distinct_i && cart_i && range_hit_i && (!wen_i || !pend_eff);
  assign cfg_apply_o = distinct_i && !latch_o && hotspot_hit_i;
  assign wr_slot     = distinct_i && !latch_o && !cfg_apply_o && wen_i && pend_eff
                       && cart_i && (age_next_i == DLY);
  assign store_we_o  = wr_slot && !wr_blocked_i;
  assign hold_o      = hold_q;

  always_comb begin
    pending_d = pending_q;
    if (distinct_i) begin
      if (latch_o)                   pending_d = 1'b1;
      else if (cfg_apply_o || wr_slot) pending_d = 1'b0;
      else                           pending_d = pend_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
      if (latch_o) hold_q <= latch_byte_i;
    end
  end

  AST_WRITE_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we_o |=> !pending_q); // R5
  AST_PENDING_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |-> (age_i <= DLY)); // R6
  AST_HOTSPOT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_apply_o |=> !pending_q); // R8
  AST_CAPTURE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> (pending_q && hold_q == $past(latch_byte_i))); // R4
endmodule

// File: rtl/sc_bank_ctrl.sv
module sc_bank_ctrl
  import sc_bank_pkg::*;
#(
  parameter int               ADDR_W   = 13,
  parameter int               OFF_W    = 11,
  parameter int               DATA_W   = 8,
  parameter int               CNT_W    = 4,
  parameter int               DELAY    = 5,
  parameter logic [BANK_W-1:0] ROM_BANK = 2'd3,
  parameter logic [ADDR_W-1:0] HOTSPOT  = 13'h1FF8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [BANK_W+OFF_W-1:0] store_addr_o,
  output logic                    store_we_o,
  output logic [DATA_W-1:0]       store_wdata_o
);
  localparam int RANGE_W = OFF_W + 1 - DATA_W;

  logic             distinct, age_clr, cfg_apply, wen, wr_blocked;
  logic             cart, range_hit, hotspot_hit;
  logic [CNT_W-1:0] age, age_next;
  logic [DATA_W-1:0] hold;

  assign cart        = addr_i[ADDR_W-1];
  assign range_hit   = (addr_i[OFF_W:DATA_W] == '0);
  assign hotspot_hit = (addr_i == HOTSPOT);

  sc_access_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tracker (
    .clk_i, .rst_ni, .addr_i,
    .age_clr_i (age_clr),
    .distinct_o(distinct),
    .age_o     (age),
    .age_next_o(age_next)
  );

  sc_write_sequencer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DELAY(DELAY)) u_seq (
    .clk_i, .rst_ni,
    .distinct_i   (distinct),
    .cart_i       (cart),
    .range_hit_i  (range_hit),
    .hotspot_hit_i(hotspot_hit),
    .latch_byte_i (addr_i[DATA_W-1:0]),
    .age_i        (age),
    .age_next_i   (age_next),
    .wen_i        (wen),
    .wr_blocked_i (wr_blocked),
    .latch_o      (age_clr),
    .cfg_apply_o  (cfg_apply),
    .hold_o       (hold),
    .store_we_o   (store_we_o)
  );

  sc_slot_mapper #(.OFF_W(OFF_W), .DATA_W(DATA_W), .ROM_BANK(ROM_BANK)) u_map (
    .clk_i, .rst_ni,
    .cfg_apply_i (cfg_apply),
    .cfg_byte_i  (hold),
    .slot_i      (addr_i[OFF_W]),
    .off_i       (addr_i[OFF_W-1:0]),
    .store_addr_o(store_addr_o),
    .wen_o       (wen),
    .wr_blocked_o(wr_blocked)
  );

  assign store_wdata_o = hold;

  AST_NO_ROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we_o |-> (store_addr_o[BANK_W+OFF_W-1:OFF_W] != ROM_BANK)); // R7
  AST_WE_NEEDS_CART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we_o |-> cart); // R10
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_addr_o[OFF_W-1:0] == addr_i[OFF_W-1:0]); // R1
  initial begin
    AST_PARAM_FIT: assert (RANGE_W >= 1); // R4
  end
endmodule

// File: tb/sc_bank_ctrl_bench.sv
module sc_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [12:0] store_addr;
  logic        store_we;
  logic [7:0]  store_wdata;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  sc_bank_ctrl u_sc_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .store_addr_o(store_addr), .store_we_o(store_we), .store_wdata_o(store_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] lo_bank(input int i);
    case (i)
      0: return 2'd0; 1: return 2'd1; 2: return 2'd2; 3: return 2'd0;
      4: return 2'd1; 5: return 2'd2; 6: return 2'd0; default: return 2'd1;
    endcase
  endfunction
  function automatic logic [1:0] hi_bank(input int i);
    case (i)
      0: return 2'd3; 1: return 2'd3; 2: return 2'd3; 3: return 2'd1;
      4: return 2'd2; 5: return 2'd0; 6: return 2'd2; default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, outputs settle combinationally; sample 1 time unit later
  task automatic step(input logic [12:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  task automatic fillers(input int n, input logic [12:0] base, input string tag);
    for (int k = 1; k <= n; k++) begin
      step(base + 13'(k));
      chk(store_we == 1'b0, tag, {31'd0, store_we}, 32'd0);
    end
  endtask

  task automatic configure(input logic [7:0] c);
    step({5'b10000, c});
    step(13'h1FF8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(store_we == 1'b0, "R2 reset strobe", {31'd0, store_we}, 32'd0);
    rst_n = 1'b1;

    // R2 reset mapping: lower bank 0, upper bank 3
    step(13'h1234);
    chk(store_addr == {2'd0, 11'h234}, "R2 reset lower map", {19'd0, store_addr}, {19'd0, 2'd0, 11'h234});
    step(13'h1ABC);
    chk(store_addr == {2'd3, 11'h2BC}, "R2 reset upper map", {19'd0, store_addr}, {19'd0, 2'd3, 11'h2BC});
    // R2 writes disabled after reset: a capture then five accesses must not write
    step(13'h1055);
    fillers(4, 13'h0100, "R2 no write fill");
    step(13'h1300);
    chk(store_we == 1'b0, "R2 writes disabled", {31'd0, store_we}, 32'd0);
    fillers(6, 13'h0180, "R2 flush");

    // R8/R1/R7 sweep of all map indices, write enable on and off
    for (int idx = 0; idx < 8; idx++) begin
      for (int w = 0; w < 2; w++) begin
        logic [7:0]  c, d;
        logic [12:0] tgt;
        logic [1:0]  eb;
        bit          upper, exp_we;
        c = {3'b000, 3'(idx), 1'(w), 1'b0};
        configure(c);
        step(13'h1123);
        chk(store_addr == {lo_bank(idx), 11'h123}, "R8 lower bank", {19'd0, store_addr}, {19'd0, lo_bank(idx), 11'h123});
        chk(store_we == 1'b0, "R8 no stray write", {31'd0, store_we}, 32'd0);
        step(13'h1A45);
        chk(store_addr == {hi_bank(idx), 11'h245}, "R1 upper bank", {19'd0, store_addr}, {19'd0, hi_bank(idx), 11'h245});
        d = {3'(idx), 1'(w), 4'h5};
        step({5'b10000, d});
        fillers(4, 13'h0100, "R5 early write");
        upper = (idx % 2) == 1;
        tgt = upper ? 13'h1A10 : 13'h1210;
        eb = upper ? hi_bank(idx) : lo_bank(idx);
        exp_we = (w == 1) && !(upper && eb == 2'd3);
        step(tgt);
        chk(store_we == exp_we, "R7 write gate", {31'd0, store_we}, {31'd0, exp_we});
        if (exp_we) begin
          chk(store_wdata == d, "R5 write data", {24'd0, store_wdata}, {24'd0, d});
          chk(store_addr == {eb, 11'h210}, "R5 write addr", {19'd0, store_addr}, {19'd0, eb, 11'h210});
        end
        fillers(6, 13'h0180, "R6 flush");
      end
    end

    // R5/R6 delay sweep with writes on, map 0
    configure(8'h02);
    for (int n = 0; n <= 8; n++) begin
      bit exp_we;
      step(13'h1040 + 13'(n));
      fillers(n, 13'h0100, "R5 sweep fill");
      step(13'h1300);
      exp_we = (n == 4);
      chk(store_we == exp_we, "R5 R6 delay", {27'd0, 5'(n), store_we}, {27'd0, 5'(n), exp_we});
      fillers(6, 13'h0180, "R6 sweep flush");
    end

    // R3 repeated address counts once; repeated target does not write twice
    step(13'h1077);
    step(13'h0100);
    repeat (10) begin
      @(negedge clk); #1;
      chk(store_we == 1'b0, "R3 repeat no write", {31'd0, store_we}, 32'd0);
    end
    step(13'h0101); step(13'h0102); step(13'h0103);
    step(13'h1301);
    chk(store_we == 1'b1 && store_wdata == 8'h77, "R3 repeat counted once", {23'd0, store_we, store_wdata}, {23'd0, 1'b1, 8'h77});
    @(negedge clk); #1;
    chk(store_we == 1'b0, "R3 held target no rewrite", {31'd0, store_we}, 32'd0);
    fillers(6, 13'h0180, "R3 flush");

    // R9 capture-range access inside armed window does not recapture
    step(13'h1011);
    fillers(3, 13'h0100, "R9 fill");
    step(13'h10CC);
    chk(store_we == 1'b0, "R9 no recapture write", {31'd0, store_we}, 32'd0);
    step(13'h1400);
    chk(store_we == 1'b1 && store_wdata == 8'h11, "R9 original byte kept", {23'd0, store_we, store_wdata}, {23'd0, 1'b1, 8'h11});
    fillers(6, 13'h0180, "R9 flush");
    step(13'h1033);
    fillers(4, 13'h0100, "R9 fill2");
    step(13'h1022);
    chk(store_we == 1'b1 && store_wdata == 8'h33 && store_addr == {2'd0, 11'h022},
        "R9 capture-range target", {10'd0, store_we, store_wdata, store_addr}, {10'd0, 1'b1, 8'h33, 2'd0, 11'h022});
    fillers(6, 13'h0180, "R9 flush2");

    // R10 fifth access outside cartridge space: nothing happens, then R6 cancel
    step(13'h1066);
    fillers(4, 13'h0100, "R10 fill");
    step(13'h0FF8);
    chk(store_we == 1'b0, "R10 non-cart no write", {31'd0, store_we}, 32'd0);
    step(13'h1500);
    chk(store_we == 1'b0, "R6 cancelled after five", {31'd0, store_we}, 32'd0);
    chk(store_addr == {2'd0, 11'h500}, "R10 map unchanged", {19'd0, store_addr}, {19'd0, 2'd0, 11'h500});
    fillers(6, 13'h0180, "R10 flush");

    // R8 hotspot cancels pending write; config 0x06 = idx1, writes on
    step(13'h1006);
    step(13'h1FF8);
    fillers(3, 13'h0100, "R8 after hotspot");
    step(13'h1200);
    chk(store_we == 1'b0, "R8 hotspot clears pending", {31'd0, store_we}, 32'd0);
    chk(store_addr == {2'd1, 11'h200}, "R8 new map", {19'd0, store_addr}, {19'd0, 2'd1, 11'h200});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule